// File: doc/BRIEF.md
# Streaming 1-D Lifting Wavelet Engine

This block computes a single-level forward biorthogonal 9/7 wavelet transform of one line of signed samples. Samples arrive two at a time, as an (even, odd) pair, on a valid/ready stream. For each pair the engine produces one low-pass and one high-pass coefficient on a second valid/ready stream. The two subbands come out on separate ports, so no later reordering is needed.

All four lifting steps and the final scaling are fused into one iteration per accepted pair. The values that the next iteration needs are held in registers rather than written back. The first pair of a line only loads the pipeline. The second and third pairs apply a mirrored left border. After the last pair, two drain iterations apply a mirrored right border and flush the pending coefficients without new input. The line length comes from `len_i`, which is sampled when the first pair of a line is taken. Backpressure on the output stalls the whole engine.

Top module: `lift97_stream`

## Requirements
- R1: The lifting steps run in a fixed order, each computing y = u + rnd(c*(l + r)), where rnd(p) = (p + 8192) >>> 14 (round half up, Q2.14 factors). The order is: odd samples with c = -25987, then even samples with c = -868, then odd samples with c = 14466, then even samples with c = 7266. In each step l and r are the opposite-parity neighbours.
- R2: The low-pass output k equals rnd(14252 * s_k) of the final even value, and the high-pass output k equals rnd(-18835 * d_k) of the final odd value. Both are signed, DW+3 bits wide.
- R3: At the left border, a missing odd neighbour at index -1 takes the value of index 1 (whole-sample mirror), in every even-sample step.
- R4: At the right border, a missing even neighbour at index N takes the value of index N-2, in every odd-sample step.
- R5: Each accepted pair yields exactly one coefficient pair. Coefficient pair k becomes valid in the cycle after input pair k+2 is accepted, so the first output appears after exactly three pairs are taken.
- R6: After the last pair of a line, `in_ready_o` stays low while two drain iterations emit the last two coefficient pairs. `out_last_o` is 1 on the final coefficient pair of a line and 0 on all others. No output follows the final pair until the next line starts.
- R7: The line length N (even, at least 6) is taken from `len_i` only with the first pair of a line. Changes of `len_i` later in the line have no effect on the count or the values of the outputs.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, the outputs hold their values and `in_ready_o` is 0. No coefficient is lost or repeated.
- R9: Reset, asserted at any time, clears `out_valid_o` and `out_last_o`, sets `in_ready_o` to 1, and abandons the current line. The next pair starts a new line.
- R10: Consecutive lines are independent. Each line's outputs depend only on that line's samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_i | input | LW (12) | Line length in samples, sampled with the first pair |
| in_valid_i | input | 1 | Input pair valid |
| in_ready_o | output | 1 | Engine accepts a pair this cycle |
| in_even_i | input | DW (16) | Even-index sample, signed |
| in_odd_i | input | DW (16) | Odd-index sample, signed |
| out_valid_o | output | 1 | Coefficient pair valid |
| out_ready_i | input | 1 | Consumer takes the coefficient pair |
| out_lo_o | output | DW+3 (19) | Low-pass coefficient, signed |
| out_hi_o | output | DW+3 (19) | High-pass coefficient, signed |
| out_last_o | output | 1 | Marks the final coefficient pair of a line |

## Verification
A wrong carried value, such as a stale neighbour or a bad mirror select, corrupts a coefficient within two pairs of where the value enters. Each output is compared to a whole-array reference transform, so such an error shows up at the next output transfer. Border faults show only in the first or last one or two coefficients of a line. For that reason, impulses are placed at both ends and lines are kept as short as six samples. A phase or stall fault shows as a missing, duplicated or misflagged coefficient. It also shows as a first output that arrives after the wrong number of accepted pairs, or as `in_ready_o` rising during the drain.

// File: rtl/lift_pkg.sv
package lift_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DR1  = 2'd2,
    PH_DR2  = 2'd3
  } phase_e;
endpackage

// File: rtl/lift_mac.sv
// y = u + round(c * (l + r)), round half up at FRAC fraction bits
module lift_mac #(
  parameter int IW   = 19,
  parameter int CW   = 16,
  parameter int FRAC = 14
) (
  input  logic signed [IW-1:0] u_i,
  input  logic signed [IW-1:0] l_i,
  input  logic signed [IW-1:0] r_i,
  input  logic signed [CW-1:0] c_i,
  output logic signed [IW-1:0] y_o
);
  localparam int PW = IW + 1 + CW;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

  logic signed [IW:0]   sum;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] shf;

  always_comb begin
    sum  = $signed({l_i[IW-1], l_i}) + $signed({r_i[IW-1], r_i});
    prod = PW'(sum) * PW'(c_i);
    rnd  = prod + HALF;
    shf  = rnd >>> FRAC;
    y_o  = u_i + $signed(shf[IW-1:0]);
  end
endmodule

// File: rtl/lift_core.sv
// One fused iteration: four lifting steps plus scaling, border mirrors by select
module lift_core #(
  parameter int IW   = 19,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter logic signed [CW-1:0] C_A  = -16'sd25987,
  parameter logic signed [CW-1:0] C_B  = -16'sd868,
  parameter logic signed [CW-1:0] C_G  = 16'sd14466,
  parameter logic signed [CW-1:0] C_D  = 16'sd7266,
  parameter logic signed [CW-1:0] C_LO = 16'sd14252,
  parameter logic signed [CW-1:0] C_HI = -16'sd18835
) (
  input  logic signed [IW-1:0] xe_p_i,
  input  logic signed [IW-1:0] xo_p_i,
  input  logic signed [IW-1:0] xe_n_i,
  input  logic signed [IW-1:0] d1_pp_i,
  input  logic signed [IW-1:0] s1_pp_i,
  input  logic signed [IW-1:0] d2_ppp_i,
  input  logic                 mir_d1_i,
  input  logic                 mir_d2_i,
  input  logic                 mir_s1_i,
  output logic signed [IW-1:0] d1_o,
  output logic signed [IW-1:0] s1_o,
  output logic signed [IW-1:0] d2_o,
  output logic signed [IW-1:0] lo_o,
  output logic signed [IW-1:0] hi_o
);
  logic signed [IW-1:0] d1_left, s1_right, d2_left, s2;
  logic signed [IW-1:0] sc_in [2];
  logic signed [IW-1:0] sc_out[2];
  logic signed [CW-1:0] sc_c  [2];

  assign d1_left  = mir_d1_i ? d1_o  : d1_pp_i;
  assign s1_right = mir_s1_i ? s1_pp_i : s1_o;
  assign d2_left  = mir_d2_i ? d2_o  : d2_ppp_i;

  lift_mac #(.IW(IW), .CW(CW), .FRAC(FRAC)) u_step_a (
    .u_i(xo_p_i), .l_i(xe_p_i), .r_i(xe_n_i), .c_i(C_A), .y_o(d1_o));
  lift_mac #(.IW(IW), .CW(CW), .FRAC(FRAC)) u_step_b (
    .u_i(xe_p_i), .l_i(d1_left), .r_i(d1_o), .c_i(C_B), .y_o(s1_o));
  lift_mac #(.IW(IW), .CW(CW), .FRAC(FRAC)) u_step_g (
    .u_i(d1_pp_i), .l_i(s1_pp_i), .r_i(s1_right), .c_i(C_G), .y_o(d2_o));
  lift_mac #(.IW(IW), .CW(CW), .FRAC(FRAC)) u_step_d (
    .u_i(s1_pp_i), .l_i(d2_left), .r_i(d2_o), .c_i(C_D), .y_o(s2));

  assign sc_in[0] = s2;
  assign sc_in[1] = d2_o;
  assign sc_c[0]  = C_LO;
  assign sc_c[1]  = C_HI;

  for (genvar g = 0; g < 2; g++) begin : g_scale
    lift_mac #(.IW(IW), .CW(CW), .FRAC(FRAC)) u_scale (
      .u_i('0), .l_i(sc_in[g]), .r_i('0), .c_i(sc_c[g]), .y_o(sc_out[g]));
  end

  assign lo_o = sc_out[0];
  assign hi_o = sc_out[1];
endmodule

// File: rtl/lift_seq.sv
// Line phase tracking: load, run, two drain steps
module lift_seq
  import lift_pkg::*;
#(
  parameter int LW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] len_i,
  input  logic          in_valid_i,
  input  logic          stall_i,
  output logic          in_ready_o,
  output logic          adv_o,
  output logic          emit_o,
  output logic          mir_d1_o,
  output logic          mir_d2_o,
  output logic          mir_s1_o,
  output logic          mir_e_o,
  output logic          last_o,
  output phase_e        ph_o
);
  localparam int KW = LW - 1;

  phase_e        ph;
  logic [KW-1:0] k, npairs;
  logic          take;

  assign ph_o       = ph;
  assign in_ready_o = (ph == PH_IDLE || ph == PH_RUN) && !stall_i;
  assign take       = in_valid_i && in_ready_o;
  assign adv_o      = take || ((ph == PH_DR1 || ph == PH_DR2) && !stall_i);
  assign emit_o     = (ph == PH_RUN && k >= KW'(2)) || ph == PH_DR1 || ph == PH_DR2;
  assign mir_d1_o   = (ph == PH_RUN) && (k == KW'(1));
  assign mir_d2_o   = (ph == PH_RUN) && (k == KW'(2));
  assign mir_e_o    = (ph == PH_DR1);
  assign mir_s1_o   = (ph == PH_DR2);
  assign last_o     = (ph == PH_DR2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph     <= PH_IDLE;
      k      <= '0;
      npairs <= '0;
    end else if (adv_o) begin
      unique case (ph)
        PH_IDLE: begin
          npairs <= len_i[LW-1:1];
          k      <= KW'(1);
          ph     <= PH_RUN;
        end
        PH_RUN: begin
          k <= k + KW'(1);
          if (k == npairs - KW'(1)) ph <= PH_DR1;
        end
        PH_DR1:  ph <= PH_DR2;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lift97_stream.sv
module lift97_stream
  import lift_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 3,
  parameter int CW    = 16,
  parameter int FRAC  = 14,
  parameter int LW    = 12,
  parameter logic signed [CW-1:0] C_A  = -16'sd25987,
  parameter logic signed [CW-1:0] C_B  = -16'sd868,
  parameter logic signed [CW-1:0] C_G  = 16'sd14466,
  parameter logic signed [CW-1:0] C_D  = 16'sd7266,
  parameter logic signed [CW-1:0] C_LO = 16'sd14252,
  parameter logic signed [CW-1:0] C_HI = -16'sd18835,
  localparam int IW = DW + GUARD
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LW-1:0]        len_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic signed [DW-1:0] in_even_i,
  input  logic signed [DW-1:0] in_odd_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic signed [IW-1:0] out_lo_o,
  output logic signed [IW-1:0] out_hi_o,
  output logic                 out_last_o
);
  phase_e ph;
  logic   stall, adv, emit, mir_d1, mir_d2, mir_s1, mir_e, last_c;

  logic signed [IW-1:0] xe_p, xo_p, d1_pp, s1_pp, d2_ppp;
  logic signed [IW-1:0] xe_in, xo_in, xe_n;
  logic signed [IW-1:0] d1_c, s1_c, d2_c, lo_c, hi_c;

  assign stall = out_valid_o && !out_ready_i;
  assign xe_in = {{GUARD{in_even_i[DW-1]}}, in_even_i};
  assign xo_in = {{GUARD{in_odd_i[DW-1]}}, in_odd_i};
  // right border: next even sample mirrors to the previous one
  assign xe_n  = mir_e ? xe_p : xe_in;

  lift_seq #(.LW(LW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .len_i     (len_i),
    .in_valid_i(in_valid_i),
    .stall_i   (stall),
    .in_ready_o(in_ready_o),
    .adv_o     (adv),
    .emit_o    (emit),
    .mir_d1_o  (mir_d1),
    .mir_d2_o  (mir_d2),
    .mir_s1_o  (mir_s1),
    .mir_e_o   (mir_e),
    .last_o    (last_c),
    .ph_o      (ph)
  );

  lift_core #(
    .IW(IW), .CW(CW), .FRAC(FRAC),
    .C_A(C_A), .C_B(C_B), .C_G(C_G), .C_D(C_D), .C_LO(C_LO), .C_HI(C_HI)
  ) u_core (
    .xe_p_i  (xe_p),
    .xo_p_i  (xo_p),
    .xe_n_i  (xe_n),
    .d1_pp_i (d1_pp),
    .s1_pp_i (s1_pp),
    .d2_ppp_i(d2_ppp),
    .mir_d1_i(mir_d1),
    .mir_d2_i(mir_d2),
    .mir_s1_i(mir_s1),
    .d1_o    (d1_c),
    .s1_o    (s1_c),
    .d2_o    (d2_c),
    .lo_o    (lo_c),
    .hi_o    (hi_c)
  );

  // carried state, shifted by one iteration per advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xe_p   <= '0;
      xo_p   <= '0;
      d1_pp  <= '0;
      s1_pp  <= '0;
      d2_ppp <= '0;
    end else if (adv) begin
      xe_p   <= xe_n;
      xo_p   <= xo_in;
      d1_pp  <= d1_c;
      s1_pp  <= s1_c;
      d2_ppp <= d2_c;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      out_lo_o    <= '0;
      out_hi_o    <= '0;
    end else if (adv && emit) begin
      out_valid_o <= 1'b1;
      out_last_o  <= last_c;
      out_lo_o    <= lo_c;
      out_hi_o    <= hi_c;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/lift97_stream_chk.sv
module lift97_stream_chk
  import lift_pkg::*;
#(
  parameter int IW = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [IW-1:0] out_lo_o,
  input logic [IW-1:0] out_hi_o,
  input logic          out_last_o,
  input phase_e        ph
);
  logic stalled;
  assign stalled = out_valid_o && !out_ready_i;

  a_r8_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stalled |=> out_valid_o && $stable(out_lo_o) && $stable(out_hi_o) && $stable(out_last_o));

  a_r8_no_take_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stalled |-> !in_ready_o);

  a_r6_drain_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_DR1 || ph == PH_DR2) |-> !in_ready_o);

  a_r6_last_has_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  a_r6_last_ends_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_last_o && stalled) |-> ph == PH_IDLE);

  a_r5_drain_emits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_DR1 && !stalled) |=> out_valid_o && !out_last_o && ph == PH_DR2);

  a_r6_final_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_DR2 && !stalled) |=> out_valid_o && out_last_o && ph == PH_IDLE);
endmodule

bind lift97_stream lift97_stream_chk #(.IW(IW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_lo_o   (out_lo_o),
  .out_hi_o   (out_hi_o),
  .out_last_o (out_last_o),
  .ph         (ph)
);

// File: tb/tb_lift97_stream.sv
`timescale 1ns/1ps
module tb_lift97_stream;
  localparam int DW = 16;
  localparam int IW = 19;
  localparam int LW = 12;
  localparam int MAXN = 64;

  // {length, pattern, seed, backpressure mode}
  localparam int NT = 10;
  localparam int TBL [NT][4] = '{
    '{6, 1, 5, 0}, '{6, 4, 0, 1}, '{6, 4, 5, 2}, '{8, 4, 7, 3},
    '{10, 0, 3, 0}, '{16, 1, 11, 2}, '{12, 2, 1234, 1},
    '{20, 3, 9000, 2}, '{32, 1, 77, 3}, '{64, 1, 4242, 2}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [LW-1:0] len_i = '0;
  logic in_valid_i = 1'b0, out_ready_i = 1'b0;
  logic signed [DW-1:0] in_even_i = '0, in_odd_i = '0;
  logic in_ready_o, out_valid_o, out_last_o;
  logic signed [IW-1:0] out_lo_o, out_hi_o;

  always #2 clk = ~clk;

  lift97_stream dut (
    .clk_i(clk), .rst_ni(rst_ni), .len_i(len_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_even_i(in_even_i), .in_odd_i(in_odd_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_lo_o(out_lo_o), .out_hi_o(out_hi_o), .out_last_o(out_last_o));

  int n_chk = 0, n_bad = 0;
  longint smp [MAXN];
  longint w [MAXN];
  longint exp_lo [MAXN/2];
  longint exp_hi [MAXN/2];
  int unsigned rs = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    rs = rs * 32'd1664525 + 32'd1013904223;
    return rs;
  endfunction

  function automatic longint mulr(input longint c, input longint v);
    return (c * v + 64'sd8192) >>> 14;
  endfunction

  // whole-array reference: R1..R4
  task automatic build(input int n, input int pat, input int seed);
    int unsigned s = seed;
    for (int i = 0; i < n; i++) begin
      case (pat)
        0: smp[i] = seed + i * 37;
        1: begin s = s * 32'd1664525 + 32'd1013904223; smp[i] = longint'((s >> 16) % 40001) - 20000; end
        2: smp[i] = seed;
        3: smp[i] = (i % 2 == 0) ? seed : -seed;
        default: smp[i] = (i == seed || i == n - 1 - seed) ? 16000 : 0;
      endcase
      w[i] = smp[i];
    end
    for (int i = 1; i < n; i += 2) w[i] += mulr(-25987, w[i-1] + ((i + 1 < n) ? w[i+1] : w[n-2]));
    for (int i = 0; i < n; i += 2) w[i] += mulr(-868, ((i == 0) ? w[1] : w[i-1]) + w[i+1]);
    for (int i = 1; i < n; i += 2) w[i] += mulr(14466, w[i-1] + ((i + 1 < n) ? w[i+1] : w[n-2]));
    for (int i = 0; i < n; i += 2) w[i] += mulr(7266, ((i == 0) ? w[1] : w[i-1]) + w[i+1]);
    for (int k = 0; k < n / 2; k++) begin
      exp_lo[k] = mulr(14252, w[2*k]);
      exp_hi[k] = mulr(-18835, w[2*k+1]);
    end
  endtask

  task automatic run_line(input int n, input int pat, input int seed, input int bp);
    int np = n / 2;
    int pidx = 0, oidx = 0, cyc = 0;
    bit first_seen = 0, stall_pend = 0, drain_bad = 0;
    longint slo = 0, shi = 0;
    build(n, pat, seed);
    while (oidx < np && cyc < 4000) begin
      @(negedge clk);
      if (stall_pend)
        chk(out_valid_o && out_lo_o == slo && out_hi_o == shi, "R8 hold", out_lo_o, slo);
      case (bp)
        0: out_ready_i = 1'b1;
        1: out_ready_i = cyc[0];
        2: out_ready_i = nxt()[20];
        default: out_ready_i = (cyc % 4 == 0);
      endcase
      in_valid_i = (pidx < np) && (bp != 2 || nxt()[18]);
      in_even_i  = DW'(smp[(2*pidx) % MAXN]);
      in_odd_i   = DW'(smp[(2*pidx+1) % MAXN]);
      // R7: length only counts at line start
      len_i      = (pidx == 0) ? LW'(n) : LW'(nxt() % 4096);
      #1;
      if (!first_seen && out_valid_o) begin
        chk(pidx == 3, "R5 first output latency", pidx, 3);
        first_seen = 1;
      end
      if (pidx == np && !(out_valid_o && out_last_o) && in_ready_o) drain_bad = 1;
      if (out_valid_o && out_ready_i) begin
        chk(out_lo_o == exp_lo[oidx], (oidx == 0) ? "R3 lo" : (oidx == np-1) ? "R4 lo" : "R2 lo",
            out_lo_o, exp_lo[oidx]);
        chk(out_hi_o == exp_hi[oidx], (oidx == 0) ? "R3 hi" : (oidx == np-1) ? "R4 hi" : "R1 hi",
            out_hi_o, exp_hi[oidx]);
        chk(out_last_o == (oidx == np - 1), "R6 last flag", out_last_o, oidx == np - 1);
        oidx++;
      end
      if (in_valid_i && in_ready_o) pidx++;
      stall_pend = out_valid_o && !out_ready_i;
      slo = out_lo_o;
      shi = out_hi_o;
      cyc++;
    end
    chk(cyc < 4000, "R5 line completes", oidx, np);
    chk(!drain_bad, "R6 ready low in drain", drain_bad, 0);
    @(negedge clk);
    in_valid_i = 1'b0;
    out_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid_o, "R6 no extra output", out_valid_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    chk(!out_valid_o && in_ready_o && !out_last_o, "R9 reset state", {out_valid_o, in_ready_o}, 1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10: lines back to back from one table
    for (int t = 0; t < NT; t++) run_line(TBL[t][0], TBL[t][1], TBL[t][2], TBL[t][3]);

    // R9: reset in the middle of a line
    build(10, 1, 99);
    out_ready_i = 1'b0;
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      in_valid_i = 1'b1;
      len_i = LW'(10);
      in_even_i = DW'(smp[2*p]);
      in_odd_i = DW'(smp[2*p+1]);
    end
    @(negedge clk);
    in_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(!out_valid_o && in_ready_o && !out_last_o, "R9 mid-line reset", out_valid_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    run_line(6, 4, 2, 1);
    run_line(14, 3, 20000, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule